// File: doc/BRIEF.md
# Multiplexed ADC Conversion Sequencer

This block sits between a host register port and an external analog-to-digital converter that serves ten channels through a multiplexer. Channels 0 to 7 are differential inputs. Channel 8 selects a +10 V reference and channel 9 selects a 0 V reference. The host writes one 16-bit control word that holds a channel number, a mask of channels allowed to convert, an optional settling-delay request and a go bit. The sequencer then drives a start/done handshake on the converter port and captures the 16-bit sample.

The converter returns two's-complement data. The block stores the sample in offset-binary form by flipping its most significant bit. At the same time it sets a completion flag in an interrupt status register, and the host clears that flag by writing a one to it. The interrupt line is high while the flag is set and the matching interrupt-enable bit is set. While a conversion is pending, the go bit reads back as one, and any further control write is discarded.

Top module: `adcseq_top`

## Requirements
- R1: After reset, all four readable registers read 0x0000 and `irq` and `cnv_start` are low. The addresses are 0 = control, 1 = interrupt enable, 2 = interrupt status, 3 = result.
- R2: A control write (address 0) that is accepted without bit 15 and has bit 0 set raises `cnv_start` for exactly one cycle, in the cycle after the write edge. During that cycle `cnv_chan` equals control bits 4:1.
- R3: When control bit 15 is set, `cnv_start` is raised `DELAY_CYC` cycles later than it would be without the flag.
- R4: Control bit 0 reads back as 1 from the write until the converter's done is taken, and as 0 afterwards. Bits 15:1 read back as written.
- R5: A control write made while a conversion is pending, whether it is in the settling delay or waiting for done, is ignored entirely. No second start is issued, and the channel and the readback stay unchanged.
- R6: Control bits 14:5 are an enable mask, where bit 5+n enables channel n. A go request whose channel is disabled in the mask, or whose channel is above 9, starts nothing, and bit 0 reads 0.
- R7: When done is taken, the result register holds the converter data with bit 15 inverted. For example, 0x0000 gives 0x8000, 0x8000 gives 0x0000 and 0x7FFF gives 0xFFFF.
- R8: When done is taken, bit 2 of the interrupt status register is set one edge later. Writing a value with bit 2 set to address 2 clears the flag. Writing a value with bit 2 clear leaves it set.
- R9: `irq` is high exactly when status bit 2 and interrupt-enable bit 2 (address 1) are both 1.
- R10: A `cnv_done` pulse that arrives while no conversion is pending changes neither the result nor the status flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Combinational register read data |
| cnv_start | output | 1 | One-cycle start pulse to the converter |
| cnv_chan | output | 4 | Multiplexer channel select |
| cnv_done | input | 1 | Converter completion strobe |
| cnv_data | input | 16 | Converter sample, two's complement |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is a second control write that lands inside a pending conversion. That write must vanish without moving the channel select or the readback. The bench reaches it by holding back the converter model's done strobe, issuing a conflicting write during both the settling window and the wait window, and only then completing the first conversion. Stray done strobes are also injected while the block is idle, to show that the result and the flag hold their values.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
   localparam logic [1:0] ADDR_CTRL = 2'd0;
   localparam logic [1:0] ADDR_IEN  = 2'd1;
   localparam logic [1:0] ADDR_IST  = 2'd2;
   localparam logic [1:0] ADDR_RES  = 2'd3;

   localparam int CTL_GO      = 0;
   localparam int CTL_CH_LO   = 1;
   localparam int CTL_MASK_LO = 5;
   localparam int CTL_SETTLE  = 15;
   localparam int FLAG_BIT    = 2;

   typedef enum logic [1:0] {
      SQ_IDLE   = 2'd0,
      SQ_SETTLE = 2'd1,
      SQ_ISSUE  = 2'd2,
      SQ_WAIT   = 2'd3
   } seq_state_t;
endpackage

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
   import adcseq_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int NUM_CH = 10,
   parameter int CH_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              busy,
   input  logic              capture,
   output logic [WORD_W-1:0] ctl_q,
   output logic              launch,
   output logic              settle,
   output logic              ien_q,
   output logic              ist_q
);
   logic [CH_W-1:0]   wr_chan;
   logic [NUM_CH-1:0] wr_mask;
   logic              chan_ok;
   logic              ctl_take;

   assign wr_chan  = wr_data[CTL_CH_LO +: CH_W];
   assign wr_mask  = wr_data[CTL_MASK_LO +: NUM_CH];
   assign ctl_take = wr_en && (wr_addr == ADDR_CTRL) && !busy;

   always_comb begin
      chan_ok = 1'b0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (wr_chan == i[CH_W-1:0]) chan_ok = wr_mask[i];
      end
   end

   assign launch = ctl_take && wr_data[CTL_GO] && chan_ok;
   assign settle = wr_data[CTL_SETTLE];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q <= '0;
         ien_q <= 1'b0;
         ist_q <= 1'b0;
      end else begin
         if (ctl_take) ctl_q <= {wr_data[WORD_W-1:1], 1'b0};
         if (wr_en && wr_addr == ADDR_IEN) ien_q <= wr_data[FLAG_BIT];
         if (capture) ist_q <= 1'b1;
         else if (wr_en && wr_addr == ADDR_IST && wr_data[FLAG_BIT]) ist_q <= 1'b0;
      end
   end
endmodule

// File: rtl/adcseq_fsm.sv
module adcseq_fsm
   import adcseq_pkg::*;
#(
   parameter int DELAY_CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic launch,
   input  logic settle,
   input  logic cnv_done,
   output logic cnv_start,
   output logic busy,
   output logic waiting,
   output logic capture
);
   localparam int CNT_W = (DELAY_CYC < 2) ? 1 : $clog2(DELAY_CYC);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DELAY_CYC - 1);

   seq_state_t       state_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            SQ_IDLE: if (launch) begin
               state_q <= settle ? SQ_SETTLE : SQ_ISSUE;
               cnt_q   <= CNT_LOAD;
            end
            SQ_SETTLE: begin
               if (cnt_q == '0) state_q <= SQ_ISSUE;
               else cnt_q <= cnt_q - 1'b1;
            end
            SQ_ISSUE: state_q <= SQ_WAIT;
            SQ_WAIT:  if (cnv_done) state_q <= SQ_IDLE;
            default:  state_q <= SQ_IDLE;
         endcase
      end
   end

   assign cnv_start = (state_q == SQ_ISSUE);
   assign busy      = (state_q != SQ_IDLE);
   assign waiting   = (state_q == SQ_WAIT);
   assign capture   = waiting && cnv_done;
endmodule

// File: rtl/adcseq_result.sv
module adcseq_result #(
   parameter int WORD_W     = 16,
   parameter bit OFFSET_BIN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [WORD_W-1:0] sample,
   output logic [WORD_W-1:0] result_q
);
   logic [WORD_W-1:0] coded;

   generate
      if (OFFSET_BIN) begin : g_offset
         assign coded = {~sample[WORD_W-1], sample[WORD_W-2:0]};
      end else begin : g_twos
         assign coded = sample;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) result_q <= '0;
      else if (capture) result_q <= coded;
   end
endmodule

// File: rtl/adcseq_top.sv
module adcseq_top
   import adcseq_pkg::*;
#(
   parameter int WORD_W     = 16,
   parameter int NUM_CH     = 10,
   parameter int CH_W       = 4,
   parameter int DELAY_CYC  = 8,
   parameter bit OFFSET_BIN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [1:0]        rd_addr,
   output logic [WORD_W-1:0] rd_data,
   output logic              cnv_start,
   output logic [CH_W-1:0]   cnv_chan,
   input  logic              cnv_done,
   input  logic [WORD_W-1:0] cnv_data,
   output logic              irq
);
   generate
      if (WORD_W != 16) begin : g_bad_word
         $error("adcseq_top: WORD_W must be 16");
      end
      if (CTL_MASK_LO + NUM_CH > CTL_SETTLE) begin : g_bad_mask
         $error("adcseq_top: channel mask overlaps settle flag");
      end
      if (CTL_CH_LO + CH_W > CTL_MASK_LO || (1 << CH_W) < NUM_CH) begin : g_bad_ch
         $error("adcseq_top: channel field does not fit");
      end
      if (DELAY_CYC < 1) begin : g_bad_delay
         $error("adcseq_top: DELAY_CYC must be at least 1");
      end
   endgenerate

   logic [WORD_W-1:0] ctl_q, result_q;
   logic launch, settle, ien_q, ist_q, busy, waiting, capture;

   adcseq_ctrl #(.WORD_W(WORD_W), .NUM_CH(NUM_CH), .CH_W(CH_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .busy(busy), .capture(capture), .ctl_q(ctl_q),
      .launch(launch), .settle(settle), .ien_q(ien_q), .ist_q(ist_q)
   );

   adcseq_fsm #(.DELAY_CYC(DELAY_CYC)) u_fsm (
      .clk(clk), .rst_n(rst_n), .launch(launch), .settle(settle),
      .cnv_done(cnv_done), .cnv_start(cnv_start), .busy(busy),
      .waiting(waiting), .capture(capture)
   );

   adcseq_result #(.WORD_W(WORD_W), .OFFSET_BIN(OFFSET_BIN)) u_res (
      .clk(clk), .rst_n(rst_n), .capture(capture), .sample(cnv_data),
      .result_q(result_q)
   );

   assign cnv_chan = ctl_q[CTL_CH_LO +: CH_W];
   assign irq      = ist_q & ien_q;

   always_comb begin
      rd_data = '0;
      unique case (rd_addr)
         ADDR_CTRL: rd_data = {ctl_q[WORD_W-1:1], busy};
         ADDR_IEN:  rd_data[FLAG_BIT] = ien_q;
         ADDR_IST:  rd_data[FLAG_BIT] = ist_q;
         ADDR_RES:  rd_data = result_q;
         default:   rd_data = '0;
      endcase
   end
endmodule

// File: rtl/adcseq_checker.sv
module adcseq_checker #(
   parameter int WORD_W     = 16,
   parameter int NUM_CH     = 10,
   parameter int CH_W       = 4,
   parameter bit OFFSET_BIN = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cnv_start,
   input logic [CH_W-1:0]   cnv_chan,
   input logic              busy,
   input logic              capture,
   input logic [WORD_W-1:0] cnv_data,
   input logic [WORD_W-1:0] result_q,
   input logic              ist_q,
   input logic              ien_q,
   input logic              irq
);
   assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnv_start |=> !cnv_start);

   assert_chan_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cnv_start |-> (cnv_chan < NUM_CH));

   assert_chan_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(cnv_chan));

   assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> ist_q);

   assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ist_q && ien_q));

   assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !capture |=> $stable(result_q));

   generate
      if (OFFSET_BIN) begin : g_ob
         assert_result_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
            capture |=> (result_q == ($past(cnv_data) ^ {1'b1, {(WORD_W-1){1'b0}}})));
      end
   endgenerate
endmodule

bind adcseq_top adcseq_checker #(
   .WORD_W(WORD_W), .NUM_CH(NUM_CH), .CH_W(CH_W), .OFFSET_BIN(OFFSET_BIN)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cnv_start(cnv_start), .cnv_chan(cnv_chan),
   .busy(busy), .capture(capture), .cnv_data(cnv_data), .result_q(result_q),
   .ist_q(ist_q), .ien_q(ien_q), .irq(irq)
);

// File: tb/adcseq_top_test.sv
module adcseq_top_test;
   localparam int D = 8;
   localparam logic [15:0] ALLMASK = 16'h7FE0;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [1:0] rd_addr = '0;
   logic [15:0] rd_data;
   logic cnv_start;
   logic [3:0] cnv_chan;
   logic cnv_done = 1'b0;
   logic [15:0] cnv_data = '0;
   logic irq;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   adcseq_top #(.DELAY_CYC(D)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .cnv_start(cnv_start), .cnv_chan(cnv_chan), .cnv_done(cnv_done),
      .cnv_data(cnv_data), .irq(irq)
   );

   task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s: got 0x%04h expected 0x%04h", tag, got, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic finish_conv(input logic [15:0] d);
      cnv_done = 1'b1; cnv_data = d;
      step();
      cnv_done = 1'b0;
   endtask

   task automatic t_reset();
      logic [15:0] v;
      for (int a = 0; a < 4; a++) begin
         bus_read(a[1:0], v);
         check("R1 reset register", v, 16'h0000);
      end
      check("R1 reset irq", {15'd0, irq}, 16'd0);
      check("R1 reset start", {15'd0, cnv_start}, 16'd0);
   endtask

   task automatic t_plain();
      logic [15:0] v;
      bus_write(2'd0, ALLMASK | 16'h0007);
      check("R2 start pulse", {15'd0, cnv_start}, 16'd1);
      check("R2 channel", {12'd0, cnv_chan}, 16'd3);
      bus_read(2'd0, v);
      check("R4 go reads 1 while busy", v, ALLMASK | 16'h0007);
      step();
      check("R2 start one cycle", {15'd0, cnv_start}, 16'd0);
      finish_conv(16'h0000);
      bus_read(2'd0, v);
      check("R4 go reads 0 after done", v, ALLMASK | 16'h0006);
      bus_read(2'd3, v);
      check("R7 zero sample", v, 16'h8000);
      bus_read(2'd2, v);
      check("R8 flag set", v, 16'h0004);
   endtask

   task automatic t_flag_clear();
      logic [15:0] v;
      bus_write(2'd2, 16'hFFFB);
      bus_read(2'd2, v);
      check("R8 write without bit2 keeps flag", v, 16'h0004);
      bus_write(2'd2, 16'h0004);
      bus_read(2'd2, v);
      check("R8 write 0x4 clears flag", v, 16'h0000);
   endtask

   task automatic t_settle();
      logic [15:0] v;
      bus_write(2'd0, 16'h8000 | ALLMASK | 16'h0011);
      for (int k = 0; k < D; k++) begin
         check("R3 no start during settle", {15'd0, cnv_start}, 16'd0);
         if (k == 2) begin
            bus_write(2'd0, ALLMASK | 16'h0003);
            k++;
            check("R5 write in settle ignored", {15'd0, cnv_start}, 16'd0);
         end
         step();
      end
      check("R3 start after delay", {15'd0, cnv_start}, 16'd1);
      check("R5 channel kept", {12'd0, cnv_chan}, 16'd8);
      step();
      bus_write(2'd0, ALLMASK | 16'h0005);
      check("R5 no second start", {15'd0, cnv_start}, 16'd0);
      check("R5 channel unchanged", {12'd0, cnv_chan}, 16'd8);
      bus_read(2'd0, v);
      check("R5 readback unchanged", v, 16'h8000 | ALLMASK | 16'h0011);
      finish_conv(16'h8000);
      bus_read(2'd3, v);
      check("R7 most negative sample", v, 16'h0000);
      bus_write(2'd2, 16'h0004);
   endtask

   task automatic t_masked();
      logic [15:0] v;
      bus_write(2'd0, (ALLMASK & ~16'h0100) | 16'h0007);
      check("R6 disabled channel no start", {15'd0, cnv_start}, 16'd0);
      bus_read(2'd0, v);
      check("R6 disabled channel go 0", v, (ALLMASK & ~16'h0100) | 16'h0006);
      step();
      check("R6 still no start", {15'd0, cnv_start}, 16'd0);
      bus_write(2'd0, ALLMASK | 16'h0015);
      check("R6 channel 10 no start", {15'd0, cnv_start}, 16'd0);
      bus_read(2'd0, v);
      check("R6 channel 10 go 0", v, ALLMASK | 16'h0014);
   endtask

   task automatic t_irq();
      logic [15:0] v;
      bus_write(2'd1, 16'h0004);
      bus_read(2'd1, v);
      check("R9 enable reads back", v, 16'h0004);
      bus_write(2'd0, ALLMASK | 16'h0013);
      check("R2 channel 9", {12'd0, cnv_chan}, 16'd9);
      step();
      check("R9 irq low while waiting", {15'd0, irq}, 16'd0);
      finish_conv(16'h7FFF);
      check("R9 irq high", {15'd0, irq}, 16'd1);
      bus_read(2'd3, v);
      check("R7 max sample", v, 16'hFFFF);
      bus_write(2'd1, 16'h0000);
      check("R9 irq masked", {15'd0, irq}, 16'd0);
      bus_write(2'd1, 16'h0004);
      check("R9 irq back", {15'd0, irq}, 16'd1);
      bus_write(2'd2, 16'h0004);
      check("R9 irq after clear", {15'd0, irq}, 16'd0);
   endtask

   task automatic t_stray();
      logic [15:0] v;
      finish_conv(16'h1234);
      bus_read(2'd3, v);
      check("R10 stray done result", v, 16'hFFFF);
      bus_read(2'd2, v);
      check("R10 stray done flag", v, 16'h0000);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_plain();
      t_flag_clear();
      t_settle();
      t_masked();
      t_irq();
      t_stray();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule